// File: doc/BRIEF.md
# Storage Mode Pushbutton Decoder

This block turns three active-low front-panel pushbuttons (write, store and fast) into one registered mode selection. Each button line first passes through a two-flop synchroniser and a debounce filter. The filtered press is then inverted into an active-high request. A mode is accepted only while its own button is the sole button held down. The accepted mode is kept in storage flip-flops after the button is released.

Any press in which two or three buttons are held together is refused, and the mode already stored stays in place. The outputs are the three one-hot mode lines and a separately registered complement of the fast line. The erase sequencer uses that complement to enable its trigger set path. Reset selects the write mode.

Top module: `storageModeDecoder`

## Requirements
- R1: After reset the mode outputs read {write, store, fast} = 100 and the fast complement output reads 1.
- R2: When the write button alone is held low past the debounce time, the mode becomes 100.
- R3: When the store button alone is held low past the debounce time, the mode becomes 010.
- R4: When the fast button alone is held low past the debounce time, the mode becomes 001 and the fast complement output becomes 0.
- R5: Releasing all buttons leaves the stored mode unchanged.
- R6: While two or three buttons are held low together, the stored mode does not change.
- R7: The fast complement output is always the inverse of the fast mode output.
- R8: Exactly one of the three mode outputs is high at all times.
- R9: A button pulse that stays low for fewer cycles than the debounce time has no effect on the mode.
- R10: A single press is not accepted before DEBOUNCE_CYCLES clock cycles have passed, and is accepted within DEBOUNCE_CYCLES + 4 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| writeBtnN | input | 1 | Write button, low when pressed |
| storeBtnN | input | 1 | Store button, low when pressed |
| fastBtnN | input | 1 | Fast button, low when pressed |
| writeMode | output | 1 | Write mode selected |
| storeMode | output | 1 | Store mode selected |
| fastMode | output | 1 | Fast mode selected |
| fastModeN | output | 1 | Registered complement of fastMode, goes to the erase sequencer |

## Verification
The hardest case to reach is an overlapping hand-over. In it, a second button goes down while the first is still held, and the first is released afterwards. The block must ignore the overlap and then accept the remaining single button. The stimulus walks through button patterns such as fast alone, then fast and write together, then write alone, holding each pattern beyond the debounce time. A short-pulse test and a test that samples just before and just after the debounce boundary cover the filter.

// File: rtl/modeSelPkg.sv
package modeSelPkg;
  localparam int NUM_BTN   = 3;
  localparam int BTN_WRITE = 2;
  localparam int BTN_STORE = 1;
  localparam int BTN_FAST  = 0;

  localparam logic [NUM_BTN-1:0] MODE_WRITE = 3'b100;
  localparam logic [NUM_BTN-1:0] MODE_STORE = 3'b010;
  localparam logic [NUM_BTN-1:0] MODE_FAST  = 3'b001;

  typedef struct packed {
    logic loadWrite;
    logic loadStore;
    logic loadFast;
  } modeStrobeT;
endpackage

// File: rtl/btnFilter.sv
module btnFilter #(
  parameter int DEBOUNCE_CYCLES = 1250000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawN,
  output logic stableN
);
  localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cntQ;
  logic                   stableQ;
  logic                   syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawN};
  end

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      stableQ <= 1'b1;
    end else if (syncOut == stableQ) begin
      cntQ <= '0;
    end else if (cntQ == CNT_LAST) begin
      cntQ    <= '0;
      stableQ <= syncOut;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  assign stableN = stableQ;

  // R9
  filter_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stableQ != $past(stableQ)) |-> ($past(syncOut) == stableQ));
endmodule

// File: rtl/modeSelDatapath.sv
module modeSelDatapath
  import modeSelPkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1250000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BTN-1:0] btnN,
  input  modeStrobeT         strobe,
  output logic [NUM_BTN-1:0] req,
  output logic [NUM_BTN-1:0] mode,
  output logic               fastN
);
  logic [NUM_BTN-1:0] stableN;
  logic [NUM_BTN-1:0] modeQ;
  logic               fastNQ;
  logic               anyLoad;

  for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
    btnFilter #(
      .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
      .SYNC_STAGES(2)
    ) u_filter (
      .clk    (clk),
      .rstN   (rstN),
      .rawN   (btnN[i]),
      .stableN(stableN[i])
    );
  end

  assign req     = ~stableN;
  assign anyLoad = strobe.loadWrite | strobe.loadStore | strobe.loadFast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= MODE_WRITE;
      fastNQ <= 1'b1;
    end else if (anyLoad) begin
      modeQ  <= {strobe.loadWrite, strobe.loadStore, strobe.loadFast};
      fastNQ <= ~strobe.loadFast;
    end
  end

  assign mode  = modeQ;
  assign fastN = fastNQ;

  // R8
  onehot_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(modeQ) == 1);
  // R7
  fast_compl_chk: assert property (@(posedge clk) disable iff (!rstN)
    fastNQ == ~modeQ[BTN_FAST]);
  // R5
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyLoad |=> $stable(modeQ));
  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWrite |=> modeQ == MODE_WRITE);
  // R4
  load_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFast |=> (modeQ == MODE_FAST && !fastNQ));
endmodule

// File: rtl/modeSelControl.sv
module modeSelControl
  import modeSelPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_BTN-1:0] req,
  output modeStrobeT         strobe
);
  logic writeOnly;
  logic storeOnly;
  logic fastOnly;

  always_comb begin
    writeOnly = req[BTN_WRITE] & ~req[BTN_STORE] & ~req[BTN_FAST];
    storeOnly = req[BTN_STORE] & ~req[BTN_WRITE] & ~req[BTN_FAST];
    fastOnly  = req[BTN_FAST]  & ~req[BTN_WRITE] & ~req[BTN_STORE];
    strobe.loadWrite = writeOnly;
    strobe.loadStore = storeOnly;
    strobe.loadFast  = fastOnly;
  end

  // R6
  multi_press_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(req) > 1) |-> (strobe == '0));
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));
endmodule

// File: rtl/storageModeDecoder.sv
module storageModeDecoder
  import modeSelPkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rstN,
  input  logic writeBtnN,
  input  logic storeBtnN,
  input  logic fastBtnN,
  output logic writeMode,
  output logic storeMode,
  output logic fastMode,
  output logic fastModeN
);
  logic [NUM_BTN-1:0] btnN;
  logic [NUM_BTN-1:0] req;
  logic [NUM_BTN-1:0] mode;
  modeStrobeT         strobe;

  assign btnN = {writeBtnN, storeBtnN, fastBtnN};

  modeSelDatapath #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .btnN  (btnN),
    .strobe(strobe),
    .req   (req),
    .mode  (mode),
    .fastN (fastModeN)
  );

  modeSelControl u_control (
    .clk   (clk),
    .rstN  (rstN),
    .req   (req),
    .strobe(strobe)
  );

  assign writeMode = mode[BTN_WRITE];
  assign storeMode = mode[BTN_STORE];
  assign fastMode  = mode[BTN_FAST];
endmodule

// File: tb/storageModeDecoder_tb.sv
module storageModeDecoder_tb;
  localparam int DEB    = 8;
  localparam int SETTLE = DEB + 10;
  localparam int NVEC   = 14;
  // each entry: {btnN write,store,fast (low = pressed), expected mode write,store,fast}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b111_100, // R1 idle after reset
    6'b110_001, // R4 fast alone
    6'b111_001, // R5 release keeps fast
    6'b101_010, // R3 store alone
    6'b111_010, // R5
    6'b100_010, // R6 store+fast
    6'b000_010, // R6 all three
    6'b011_100, // R2 write alone
    6'b001_100, // R6 write+store overlap
    6'b101_010, // R3 hand-over to store
    6'b110_001, // R4
    6'b010_001, // R6 write+fast overlap
    6'b011_100, // R2 hand-over to write
    6'b111_100  // R5
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic writeBtnN = 1'b1, storeBtnN = 1'b1, fastBtnN = 1'b1;
  logic writeMode, storeMode, fastMode, fastModeN;
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  storageModeDecoder #(.DEBOUNCE_CYCLES(DEB)) u_dut (
    .clk(clk), .rstN(rstN),
    .writeBtnN(writeBtnN), .storeBtnN(storeBtnN), .fastBtnN(fastBtnN),
    .writeMode(writeMode), .storeMode(storeMode), .fastMode(fastMode),
    .fastModeN(fastModeN)
  );

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkMode(input string tag, input logic [2:0] expMode);
    logic [2:0] act;
    act = {writeMode, storeMode, fastMode};
    testsRun++;
    if (act !== expMode) begin
      testsFailed++;
      $display("FAIL %s: mode actual=%b expected=%b", tag, act, expMode);
    end
    testsRun++;
    if (fastModeN !== ~expMode[0]) begin
      testsFailed++;
      $display("FAIL R7 (%s): fastModeN actual=%b expected=%b", tag, fastModeN, ~expMode[0]);
    end
    testsRun++;
    if ($countones(act) != 1) begin
      testsFailed++;
      $display("FAIL R8 (%s): mode actual=%b expected one-hot", tag, act);
    end
  endtask

  initial begin
    waitCycles(3);
    checkMode("R1 reset held", 3'b100);
    rstN = 1'b1;
    waitCycles(2);
    checkMode("R1 after reset", 3'b100);

    for (int v = 0; v < NVEC; v++) begin
      {writeBtnN, storeBtnN, fastBtnN} = VEC[v][5:3];
      waitCycles(SETTLE);
      checkMode($sformatf("vector %0d (R2-R6)", v), VEC[v][2:0]);
    end

    // R9: short glitch on store is ignored
    storeBtnN = 1'b0;
    waitCycles(DEB - 2);
    storeBtnN = 1'b1;
    waitCycles(SETTLE);
    checkMode("R9 short store pulse", 3'b100);

    // R10: not accepted before the debounce time, accepted right after
    fastBtnN = 1'b0;
    waitCycles(DEB);
    checkMode("R10 before debounce", 3'b100);
    waitCycles(4);
    checkMode("R10 after debounce", 3'b001);
    fastBtnN = 1'b1;
    waitCycles(SETTLE);

    // R1: reset mid-operation restores write
    rstN = 1'b0;
    waitCycles(2);
    checkMode("R1 reset from fast", 3'b100);
    rstN = 1'b1;
    waitCycles(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule